// File: doc/BRIEF.md
# Cascaded Free-Running Time Counter

This block builds a wide free-running time base out of two narrow counter channels. The low channel counts ticks of a selectable prescaled clock and wraps through its maximum value. Two compare registers turn its count into a square wave: the wave goes high when the count reaches the set compare and goes low when it reaches the clear compare. The high channel uses the rising edges of that wave as its count clock, so it advances once each time the low channel wraps. The full time value is the high count placed above the low count.

Each channel has to be enabled by a command before it advances. A single block-wide synchronise command zeroes both channels, the wave and the prescaler in the same clock. Software reads each half through a registered read port. To get a tear-free value it reads the high half, then the low half, then the high half again, and retries whenever the two high reads differ. This works because the high channel only catches up with a low wrap one clock after the wrap.

Top module: `cascade_timer`

## Requirements
- R1: After a synchronous reset both counts read 0, the wave output is low, both channels are disabled, and the set and clear compares hold 0 and half the count range (0x8000 at the default 16-bit width).
- R2: An enabled low channel adds one on each selected tick, goes from all ones to 0, and is not cleared by a clear-compare match.
- R3: The tick source follows `div_sel`. Codes 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 clocks; these are counted by a prescaler that is zeroed by reset and by the synchronise command. Code 4 uses the `slow_tick` strobe. Codes 5 to 7 give no ticks.
- R4: `wave_o` goes high on the counting step at which the low count becomes equal to the set compare. It goes low on the step at which the count becomes equal to the clear compare. If both compares hold the same value, the set wins.
- R5: An enabled high channel adds one in the clock after each rising edge of `wave_o`. This is one clock after the low channel wraps to 0 with the default compares.
- R6: `sync` zeroes both counts, `wave_o` and the prescaler at the next edge, and it overrides any counting step in that same clock.
- R7: `en_set[i]` enables channel i and `en_clr[i]` disables it, with bit 0 the low channel and bit 1 the high channel. If both bits for a channel are given in the same clock, the clear wins. A disabled channel holds its count.
- R8: A read with `rd_en` high returns, one clock later, the low count (`rd_hi`=0) or the high count (`rd_hi`=1) as it was before that edge, with `rd_valid` high. `rd_data` holds its value between reads.
- R9: The high-low-high read sequence, retried whenever the two high values differ, yields the true 32-bit time value at the moment of the low read.
- R10: `cmp_wr` with `cmp_slot`=0 writes the set compare and with `cmp_slot`=1 writes the clear compare. The new value takes effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 3 | Tick source select |
| slow_tick | input | 1 | Slow-clock tick strobe, one clock wide |
| en_set | input | 2 | Per-channel enable command |
| en_clr | input | 2 | Per-channel disable command |
| sync | input | 1 | Block-wide counter zeroing command |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_slot | input | 1 | Compare select: 0 set, 1 clear |
| cmp_wdata | input | 16 | Compare write value |
| rd_en | input | 1 | Read request |
| rd_hi | input | 1 | Read half select: 0 low, 1 high |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | Read data valid, one clock after `rd_en` |
| wave_o | output | 1 | Low channel square wave, clock of high channel |

## Verification
Two events can fall in the same clock: the synchronise command and a counting step of the low channel, including its wrap to 0, which also produces the rising wave edge that clocks the high channel. The bench provokes this by issuing `sync` at a sweep of intervals around one full wrap period. One of these intervals lands on the wrap step itself, and another lands one clock later, when the wave edge would advance the high channel. A behavioural model compares every read and the wave level on every clock, and the sweep is judged correct only if `sync` wins each time. The bench also races the high-low-high read sequence against wraps and checks that every value it accepts matches the model.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;

  // Prescaler option k divides the master clock by 2**div_log2(k).
  function automatic int div_log2(input int idx);
    return 2 * idx + 1;
  endfunction

  typedef enum logic {
    CMP_SLOT_SET = 1'b0,
    CMP_SLOT_CLR = 1'b1
  } cmp_slot_e;

  localparam int NUM_CHANNELS = 2;
  localparam int CH_LO        = 0;
  localparam int CH_HI        = 1;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import cascade_timer_pkg::*;
#(
  parameter int DIV_OPTS = 4,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             slow_tick,
  output logic             tick
);

  localparam int PRE_W = div_log2(DIV_OPTS - 1);

  logic [PRE_W-1:0]    pre_cnt;
  logic [DIV_OPTS-1:0] opt_tick;

  always_ff @(posedge clk) begin
    if (rst || clr) pre_cnt <= '0;
    else            pre_cnt <= pre_cnt + 1'b1;
  end

  // One tick per 2**LG clocks: the low LG bits all ones.
  for (genvar g = 0; g < DIV_OPTS; g++) begin : g_opt
    localparam int LG = div_log2(g);
    assign opt_tick[g] = &pre_cnt[LG-1:0];
  end

  always_comb begin
    tick = 1'b0;
    for (int k = 0; k < DIV_OPTS; k++) begin
      if (div_sel == SEL_W'(k)) tick = opt_tick[k];
    end
    if (div_sel == SEL_W'(DIV_OPTS)) tick = slow_tick;
  end

endmodule

// File: rtl/wave_channel.sv
module wave_channel
  import cascade_timer_pkg::*;
#(
  parameter int               CNT_W  = 16,
  parameter logic [CNT_W-1:0] SET_INIT = '0,
  parameter logic [CNT_W-1:0] CLR_INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic             en,
  input  logic             tick,
  input  logic             cmp_wr,
  input  cmp_slot_e        cmp_slot,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp_set,
  output logic             wave
);

  logic [CNT_W-1:0] cmp_clr;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_set <= SET_INIT;
      cmp_clr <= CLR_INIT;
    end else if (cmp_wr) begin
      if (cmp_slot == CMP_SLOT_CLR) cmp_clr <= cmp_wdata;
      else                          cmp_set <= cmp_wdata;
    end
  end

  // Compare events fire on the counting step that reaches the value.
  always_ff @(posedge clk) begin
    if (rst || sync) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (en && tick) begin
      cnt <= cnt_nxt;
      if (cnt_nxt == cmp_set)      wave <= 1'b1;
      else if (cnt_nxt == cmp_clr) wave <= 1'b0;
    end
  end

endmodule

// File: rtl/chain_channel.sv
module chain_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic             en,
  input  logic             src_clk,
  output logic [CNT_W-1:0] cnt
);

  logic src_q;
  logic src_rise;

  assign src_rise = src_clk && !src_q;

  always_ff @(posedge clk) begin
    if (rst || sync) begin
      src_q <= 1'b0;
      cnt   <= '0;
    end else begin
      src_q <= src_clk;
      if (en && src_rise) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import cascade_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DIV_OPTS = 4,
  parameter int SEL_W    = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SEL_W-1:0]        div_sel,
  input  logic                    slow_tick,
  input  logic [NUM_CHANNELS-1:0] en_set,
  input  logic [NUM_CHANNELS-1:0] en_clr,
  input  logic                    sync,
  input  logic                    cmp_wr,
  input  logic                    cmp_slot,
  input  logic [CNT_W-1:0]        cmp_wdata,
  input  logic                    rd_en,
  input  logic                    rd_hi,
  output logic [CNT_W-1:0]        rd_data,
  output logic                    rd_valid,
  output logic                    wave_o
);

  localparam logic [CNT_W-1:0] SET_INIT = '0;
  localparam logic [CNT_W-1:0] CLR_INIT = CNT_W'(1) << (CNT_W - 1);

  logic [NUM_CHANNELS-1:0] chan_en;
  logic                    tick;
  logic [CNT_W-1:0]        lo_cnt;
  logic [CNT_W-1:0]        hi_cnt;
  logic [CNT_W-1:0]        cmp_set;
  logic                    wave;

  // Disable wins over enable for the same channel.
  always_ff @(posedge clk) begin
    if (rst) chan_en <= '0;
    else     chan_en <= (chan_en | en_set) & ~en_clr;
  end

  tick_prescaler #(
    .DIV_OPTS (DIV_OPTS),
    .SEL_W    (SEL_W)
  ) u_pre (
    .clk       (clk),
    .rst       (rst),
    .clr       (sync),
    .div_sel   (div_sel),
    .slow_tick (slow_tick),
    .tick      (tick)
  );

  wave_channel #(
    .CNT_W    (CNT_W),
    .SET_INIT (SET_INIT),
    .CLR_INIT (CLR_INIT)
  ) u_lo (
    .clk       (clk),
    .rst       (rst),
    .sync      (sync),
    .en        (chan_en[CH_LO]),
    .tick      (tick),
    .cmp_wr    (cmp_wr),
    .cmp_slot  (cmp_slot_e'(cmp_slot)),
    .cmp_wdata (cmp_wdata),
    .cnt       (lo_cnt),
    .cmp_set   (cmp_set),
    .wave      (wave)
  );

  chain_channel #(
    .CNT_W (CNT_W)
  ) u_hi (
    .clk     (clk),
    .rst     (rst),
    .sync    (sync),
    .en      (chan_en[CH_HI]),
    .src_clk (wave),
    .cnt     (hi_cnt)
  );

  assign wave_o = wave;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_hi ? hi_cnt : lo_cnt;
    end
  end

endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sync,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             wave,
  input logic             lo_en,
  input logic             hi_en,
  input logic [CNT_W-1:0] lo,
  input logic [CNT_W-1:0] hi,
  input logic [CNT_W-1:0] cmp_set
);

  a_r2_lo_step: assert property (@(posedge clk) disable iff (rst)
    !sync |=> (lo == $past(lo) || lo == CNT_W'($past(lo) + 1'b1)));

  a_r5_hi_step: assert property (@(posedge clk) disable iff (rst)
    !sync |=> (hi == $past(hi) || hi == CNT_W'($past(hi) + 1'b1)));

  a_r7_lo_hold: assert property (@(posedge clk) disable iff (rst)
    (!lo_en && !sync) |=> $stable(lo));

  a_r7_hi_hold: assert property (@(posedge clk) disable iff (rst)
    (!hi_en && !sync) |=> $stable(hi));

  a_r6_sync_zero: assert property (@(posedge clk) disable iff (rst)
    sync |=> (lo == '0 && hi == '0 && !wave));

  a_r4_wave_rise: assert property (@(posedge clk) disable iff (rst)
    ($rose(wave) && $stable(cmp_set)) |-> lo == cmp_set);

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  a_r8_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

endmodule

bind cascade_timer cascade_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sync     (sync),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .wave     (wave_o),
  .lo_en    (chan_en[0]),
  .hi_en    (chan_en[1]),
  .lo       (lo_cnt),
  .hi       (hi_cnt),
  .cmp_set  (cmp_set)
);

// File: tb/test_cascade_timer.sv
module test_cascade_timer;

  localparam int W    = 8;
  localparam int MODV = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   div_sel = '0;
  logic         slow_tick = 1'b0;
  logic [1:0]   en_set = '0;
  logic [1:0]   en_clr = '0;
  logic         sync = 1'b0;
  logic         cmp_wr = 1'b0;
  logic         cmp_slot = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic         rd_en = 1'b0;
  logic         rd_hi = 1'b0;
  logic [W-1:0] rd_data;
  logic         rd_valid;
  logic         wave_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    poll_on = 1'b0;
  bit    started = 1'b0;
  bit    done = 1'b0;

  cascade_timer #(.CNT_W(W)) i_cascade_timer (
    .clk, .rst, .div_sel, .slow_tick, .en_set, .en_clr, .sync,
    .cmp_wr, .cmp_slot, .cmp_wdata, .rd_en, .rd_hi,
    .rd_data, .rd_valid, .wave_o
  );

  always #2 clk = ~clk;

  // Behavioural reference model, updated at each rising edge.
  int      m_pre, m_lo, m_hi, m_set, m_clr, e_data, m_snap;
  bit      m_wave, m_wq, e_valid;
  bit [1:0] m_en;

  always @(posedge clk) begin
    bit [1:0] en_old;
    bit tk, ed;
    int nlo, mask;
    started = 1'b1;
    if (rst) begin
      m_pre = 0; m_lo = 0; m_hi = 0; m_wave = 0; m_wq = 0; m_en = 0;
      m_set = 0; m_clr = MODV / 2; e_valid = 0; e_data = 0;
    end else begin
      e_valid = rd_en;
      if (rd_en) begin
        e_data = rd_hi ? m_hi : m_lo;
        if (!rd_hi) m_snap = m_hi * MODV + m_lo;
      end
      en_old = m_en;
      m_en = (m_en | en_set) & ~en_clr;
      if (sync) begin
        m_pre = 0; m_lo = 0; m_hi = 0; m_wave = 0; m_wq = 0;
      end else begin
        mask = (1 << (2 * int'(div_sel) + 1)) - 1;
        if (div_sel < 4)       tk = ((m_pre & mask) == mask);
        else if (div_sel == 4) tk = slow_tick;
        else                   tk = 1'b0;
        m_pre = (m_pre + 1) % 128;
        ed = m_wave && !m_wq;
        m_wq = m_wave;
        if (en_old[0] && tk) begin
          nlo = (m_lo + 1) % MODV;
          if (nlo == m_set)      m_wave = 1'b1;
          else if (nlo == m_clr) m_wave = 1'b0;
          m_lo = nlo;
        end
        if (en_old[1] && ed) m_hi = (m_hi + 1) % MODV;
      end
      if (cmp_wr) begin
        if (cmp_slot) m_clr = int'(cmp_wdata);
        else          m_set = int'(cmp_wdata);
      end
    end
  end

  // Compare outputs on every falling edge.
  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (wave_o !== m_wave) begin
        n_bad++;
        $display("FAIL R4 (%s): wave_o=%0b expected %0b at %0t", cur_req, wave_o, m_wave, $time);
      end
      n_cmp++;
      if (rd_valid !== e_valid) begin
        n_bad++;
        $display("FAIL R8 (%s): rd_valid=%0b expected %0b", cur_req, rd_valid, e_valid);
      end
      n_cmp++;
      if (int'(rd_data) !== e_data) begin
        n_bad++;
        $display("FAIL %s: rd_data=%0d expected %0d at %0t", cur_req, rd_data, e_data, $time);
      end
    end
  end

  // Background poller alternating low and high reads.
  always @(negedge clk) begin
    if (poll_on) begin
      rd_en <= 1'b1;
      rd_hi <= ~rd_hi;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_en(input logic [1:0] s, input logic [1:0] c);
    @(negedge clk); en_set = s; en_clr = c;
    @(negedge clk); en_set = '0; en_clr = '0;
  endtask

  task automatic write_cmp(input logic slot, input int v);
    @(negedge clk); cmp_wr = 1'b1; cmp_slot = slot; cmp_wdata = W'(v);
    @(negedge clk); cmp_wr = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0;
  endtask

  // R9: high-low-high read with retry.
  task automatic safe_read();
    int h1, l, h2, tries;
    tries = 0;
    do begin
      @(negedge clk); rd_en = 1'b1; rd_hi = 1'b1;
      @(negedge clk); h1 = rd_data; rd_hi = 1'b0;
      @(negedge clk); l = rd_data; rd_hi = 1'b1;
      @(negedge clk); h2 = rd_data; rd_en = 1'b0;
      tries++;
    end while (h1 != h2 && tries < 4);
    n_cmp++;
    if (h1 != h2 || (h1 * MODV + l) != m_snap) begin
      n_bad++;
      $display("FAIL R9: value=%0d expected %0d", h1 * MODV + l, m_snap);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    poll_on = 1'b1; idle(6);
    cur_req = "R7"; pulse_en(2'b01, 2'b00); idle(700);       // high disabled holds
    cur_req = "R5"; pulse_en(2'b10, 2'b00); idle(1600);
    cur_req = "R3"; div_sel = 3'd1; idle(2300);
    div_sel = 3'd2; idle(2000);
    div_sel = 3'd3; idle(1500);
    div_sel = 3'd4;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); slow_tick = (i % 3 == 0);
    end
    slow_tick = 1'b0;
    div_sel = 3'd5; idle(300);
    div_sel = 3'd0;
    cur_req = "R10"; write_cmp(1'b0, 16); write_cmp(1'b1, 64); idle(1200);
    cur_req = "R4"; write_cmp(1'b1, 16); idle(1100);
    write_cmp(1'b0, 0); write_cmp(1'b1, MODV / 2);
    cur_req = "R6";
    for (int d = 506; d <= 516; d++) begin
      pulse_sync(); idle(d);
    end
    cur_req = "R7"; pulse_en(2'b01, 2'b01); idle(300);
    pulse_en(2'b11, 2'b10); idle(700);
    cur_req = "R2"; pulse_en(2'b10, 2'b00); idle(600);
    poll_on = 1'b0;
    @(negedge clk); rd_en = 1'b0;
    cur_req = "R9";
    for (int i = 0; i < 300; i++) safe_read();
    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    done = 1'b1;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule